// File: doc/BRIEF.md
# Load-Store Byte Lane Unit

This unit sits between a 32-bit register file and a 32-bit word-wide data memory. It forms the effective byte address by adding a sign-extended 16-bit displacement to a 32-bit base. For a load, it takes the word read from memory and picks the byte or halfword that the address selects. It then sign-extends or zero-extends that value to 32 bits. For a store, it copies the low byte or low halfword of the register onto the byte lanes of the memory word and drives one write enable per lane.

Memory is little-endian: lane 0 (bits 7:0 of the word) holds the byte at the lowest address. An access of s bytes must start at an address that is a multiple of s. Any other access raises an address-error flag, and no lane is then written. The unit has no clock and no storage. Every output follows its inputs in the same cycle.

Top module: `lsu_lane_unit`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `offset` sign-extended to 32 bits, modulo 2^32.
- R2: `size` encodes 00 as byte, 01 as halfword, 10 as word and 11 as reserved. `addr_err` is 1 for a halfword with `eff_addr[0]`=1, for a word with `eff_addr[1:0]`≠0, and for the reserved code. It is 0 otherwise.
- R3: While `addr_err` is 1, `wr_be` is 4'b0000.
- R4: With `is_store`=1 and no error, `wr_be` is as follows. A byte access gives 1 shifted left by `eff_addr[1:0]`. A halfword access gives 4'b0011 at lane 0 and 4'b1100 at lane 2. A word access gives 4'b1111. With `is_store`=0, `wr_be` is 4'b0000.
- R5: `wr_data` depends on the size. A byte access gives `store_data[7:0]` copied into all four lanes. A halfword access gives `store_data[15:0]` in both halves. A word access gives `store_data` unchanged. Each enabled lane therefore receives the register's low bits.
- R6: A byte load returns byte `eff_addr[1:0]` of `mem_rdata`, where lane k is bits 8k+7:8k.
- R7: A halfword load returns `mem_rdata[15:0]` at lane 0 and `mem_rdata[31:16]` at lane 2.
- R8: For byte and halfword loads, `is_unsigned`=0 copies the top bit of the value into the upper bits, and `is_unsigned`=1 fills them with zeros. For example, with word 0xABCDE080 at lane 0, a signed halfword gives 0xFFFFE080, an unsigned halfword 0x0000E080, a signed byte 0xFFFFFF80 and an unsigned byte 0x00000080.
- R9: A word load without error returns `mem_rdata` unchanged.
- R10: While `addr_err` is 1, `load_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| size | input | 2 | Access size code |
| is_unsigned | input | 1 | Zero-extend a narrow load |
| is_store | input | 1 | 1 for store, 0 for load |
| mem_rdata | input | 32 | Word read from memory |
| store_data | input | 32 | Register value to store |
| eff_addr | output | 32 | Effective byte address |
| load_data | output | 32 | Extended load result |
| wr_data | output | 32 | Lane-placed store word |
| wr_be | output | 4 | Per-lane write enables |
| addr_err | output | 1 | Misaligned or reserved access |

## Verification
Every result is due in the same cycle as the stimulus, because no register lies on any path. The bench changes the inputs on the falling clock edge. It waits one nanosecond for the combinational logic to settle and then compares all outputs, well before the next rising edge. The sweep covers every lane, size code, signedness and direction against several data words. Further cases drive negative and wrapping displacements for the address sum.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int NBYTES = DATA_W / 8;
  localparam int LANE_W = $clog2(NBYTES);
  localparam int OFF_W  = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } lsu_size_e;

  function automatic logic [DATA_W-1:0] ext_byte(input logic [7:0] v, input logic uns);
    return {{(DATA_W-8){v[7] & ~uns}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] ext_half(input logic [15:0] v, input logic uns);
    return {{(DATA_W-16){v[15] & ~uns}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] sext_off(input logic [OFF_W-1:0] v);
    return {{(DATA_W-OFF_W){v[OFF_W-1]}}, v};
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  offset,
  input  lsu_size_e         size,
  output logic [DATA_W-1:0] eff_addr,
  output logic              misaligned
);
  logic [LANE_W-1:0] lane;

  assign eff_addr = base_addr + sext_off(offset);
  assign lane     = eff_addr[LANE_W-1:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = lane[0];
      SZ_WORD: misaligned = |lane;
      default: misaligned = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [LANE_W-1:0] lane,
  input  lsu_size_e         size,
  input  logic              is_unsigned,
  input  logic              err,
  output logic [DATA_W-1:0] load_data
);
  logic [DATA_W-1:0] byte_shift;
  logic [DATA_W-1:0] half_shift;

  assign byte_shift = mem_rdata >> {lane, 3'b000};
  assign half_shift = mem_rdata >> {lane[LANE_W-1], 4'b0000};

  always_comb begin
    if (err) begin
      load_data = '0;
    end else begin
      unique case (size)
        SZ_BYTE: load_data = ext_byte(byte_shift[7:0], is_unsigned);
        SZ_HALF: load_data = ext_half(half_shift[15:0], is_unsigned);
        default: load_data = mem_rdata;
      endcase
    end
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] store_data,
  input  logic [LANE_W-1:0] lane,
  input  lsu_size_e         size,
  input  logic              is_store,
  input  logic              err,
  output logic [DATA_W-1:0] wr_data,
  output logic [NBYTES-1:0] wr_be
);
  logic [NBYTES-1:0] be_byte;
  logic [NBYTES-1:0] be_half;
  logic [DATA_W-1:0] rep_byte;
  logic [DATA_W-1:0] rep_half;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign be_byte[i]          = (lane == LANE_W'(i));
    assign be_half[i]          = (lane[LANE_W-1] == 1'(i / 2));
    assign rep_byte[8*i +: 8]  = store_data[7:0];
  end

  for (genvar h = 0; h < NBYTES / 2; h++) begin : g_half
    assign rep_half[16*h +: 16] = store_data[15:0];
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: wr_data = rep_byte;
      SZ_HALF: wr_data = rep_half;
      default: wr_data = store_data;
    endcase
    if (!is_store || err) begin
      wr_be = '0;
    end else begin
      unique case (size)
        SZ_BYTE: wr_be = be_byte;
        SZ_HALF: wr_be = be_half;
        default: wr_be = '1;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
(
  input  logic [31:0] base_addr,
  input  logic [15:0] offset,
  input  logic [1:0]  size,
  input  logic        is_unsigned,
  input  logic        is_store,
  input  logic [31:0] mem_rdata,
  input  logic [31:0] store_data,
  output logic [31:0] eff_addr,
  output logic [31:0] load_data,
  output logic [31:0] wr_data,
  output logic [3:0]  wr_be,
  output logic        addr_err
);
  lsu_size_e         size_e;
  logic [LANE_W-1:0] lane;
  logic              misaligned;

  assign size_e   = lsu_size_e'(size);
  assign lane     = eff_addr[LANE_W-1:0];
  assign addr_err = misaligned;

  lsu_addr_gen u_addr (
    .base_addr (base_addr),
    .offset    (offset),
    .size      (size_e),
    .eff_addr  (eff_addr),
    .misaligned(misaligned)
  );

  lsu_load_align u_load (
    .mem_rdata  (mem_rdata),
    .lane       (lane),
    .size       (size_e),
    .is_unsigned(is_unsigned),
    .err        (misaligned),
    .load_data  (load_data)
  );

  lsu_store_lanes u_store (
    .store_data(store_data),
    .lane      (lane),
    .size      (size_e),
    .is_store  (is_store),
    .err       (misaligned),
    .wr_data   (wr_data),
    .wr_be     (wr_be)
  );
endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk (
  input logic [1:0]  size,
  input logic        is_unsigned,
  input logic        is_store,
  input logic [31:0] mem_rdata,
  input logic [31:0] eff_addr,
  input logic [31:0] load_data,
  input logic [3:0]  wr_be,
  input logic        addr_err
);
  always_comb begin
    AST_BE_QUIET_ON_ERR: assert (!addr_err || wr_be == 4'b0000); // R3
    AST_LOAD_ZERO_ON_ERR: assert (!addr_err || load_data == 32'h0); // R10
    AST_WORD_MISALIGN: assert (!(size == 2'b10 && eff_addr[1:0] != 2'b00) || addr_err); // R2
    AST_BYTE_NEVER_ERR: assert (size != 2'b00 || !addr_err); // R2
    AST_LOAD_NO_BE: assert (is_store || wr_be == 4'b0000); // R4
    AST_BYTE_ONE_LANE: assert (!(is_store && size == 2'b00) || $countones(wr_be) == 1); // R4
    AST_WORD_PASS: assert (!(size == 2'b10 && !addr_err) || load_data == mem_rdata); // R9
    AST_BYTE_SIGN_FILL: assert (!(size == 2'b00 && !is_unsigned)
                                || load_data[31:8] == {24{load_data[7]}}); // R8
  end
endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_chk (
  .size       (size),
  .is_unsigned(is_unsigned),
  .is_store   (is_store),
  .mem_rdata  (mem_rdata),
  .eff_addr   (eff_addr),
  .load_data  (load_data),
  .wr_be      (wr_be),
  .addr_err   (addr_err)
);

// File: tb/lsu_lane_unit_test.sv
`timescale 1ns/1ps
module lsu_lane_unit_test;
  logic        clk = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] offset = '0;
  logic [1:0]  size = '0;
  logic        is_unsigned = 1'b0;
  logic        is_store = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] store_data = '0;
  logic [31:0] eff_addr, load_data, wr_data;
  logic [3:0]  wr_be;
  logic        addr_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lsu_lane_unit uut (
    .base_addr(base_addr), .offset(offset), .size(size),
    .is_unsigned(is_unsigned), .is_store(is_store),
    .mem_rdata(mem_rdata), .store_data(store_data),
    .eff_addr(eff_addr), .load_data(load_data), .wr_data(wr_data),
    .wr_be(wr_be), .addr_err(addr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic [15:0] o, input logic [1:0] s,
                       input logic u, input logic st, input logic [31:0] rd,
                       input logic [31:0] sd);
    @(negedge clk);
    base_addr = b; offset = o; size = s; is_unsigned = u; is_store = st;
    mem_rdata = rd; store_data = sd;
    #1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hABCDE080; pats[1] = 32'h11223344;
    pats[2] = 32'h7F80FF01; pats[3] = 32'h8000_7FFF;

    // all-zero inputs: quiet outputs
    drive(32'h0, 16'h0, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R4 idle be", {28'h0, wr_be}, 32'h0);
    check("R2 idle err", {31'h0, addr_err}, 32'h0);
    check("R6 idle load", load_data, 32'h0);

    // worked examples
    drive(32'h1000_0000, 16'h0, 2'b01, 1'b0, 1'b0, 32'hABCDE080, 32'h0);
    check("R8 signed half", load_data, 32'hFFFFE080);
    drive(32'h1000_0000, 16'h0, 2'b01, 1'b1, 1'b0, 32'hABCDE080, 32'h0);
    check("R8 unsigned half", load_data, 32'h0000E080);
    drive(32'h1000_0000, 16'h0, 2'b00, 1'b0, 1'b0, 32'hABCDE080, 32'h0);
    check("R8 signed byte", load_data, 32'hFFFFFF80);
    drive(32'h1000_0000, 16'h0, 2'b00, 1'b1, 1'b0, 32'hABCDE080, 32'h0);
    check("R8 unsigned byte", load_data, 32'h00000080);

    // address sum with negative and wrapping displacements
    drive(32'h1000_0010, 16'hFFF0, 2'b10, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R1 negative offset", eff_addr, 32'h1000_0000);
    drive(32'h0000_0002, 16'h8000, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R1 wrap below zero", eff_addr, 32'hFFFF_8002);
    drive(32'hFFFF_FFFF, 16'h0003, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R1 wrap above top", eff_addr, 32'h0000_0002);
    drive(32'h0040_0000, 16'h7FFF, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R1 max positive", eff_addr, 32'h0040_7FFF);

    // sweep: lane reached via base and via displacement
    for (int via = 0; via < 2; via++)
      for (int ln = 0; ln < 4; ln++)
        for (int sz = 0; sz < 4; sz++)
          for (int un = 0; un < 2; un++)
            for (int st = 0; st < 2; st++)
              for (int p = 0; p < 4; p++) begin
                logic [31:0] b, rd, sd, e_ld, e_wd, nb, nh;
                logic [15:0] o;
                logic e_err;
                logic [3:0] e_be;
                rd = pats[p];
                sd = pats[3 - p] ^ 32'h5A5A_0000;
                if (via == 0) begin b = 32'h1000_0100 + ln; o = 16'h0; end
                else begin b = 32'h1000_0104; o = 16'(ln - 4); end
                e_err = (sz == 3) || (sz == 1 && (ln % 2) == 1) || (sz == 2 && ln != 0);
                nb = (rd / (32'd1 << (8 * ln))) % 256;
                nh = (rd / (32'd1 << (16 * (ln / 2)))) % 65536;
                if (e_err) e_ld = 0;
                else if (sz == 0) e_ld = nb + ((un == 0 && nb >= 128) ? 32'hFFFFFF00 : 0);
                else if (sz == 1) e_ld = nh + ((un == 0 && nh >= 32768) ? 32'hFFFF0000 : 0);
                else e_ld = rd;
                if (sz == 0) e_wd = (sd % 256) * 32'h01010101;
                else if (sz == 1) e_wd = (sd % 65536) * 32'h00010001;
                else e_wd = sd;
                if (st == 0 || e_err) e_be = 4'd0;
                else if (sz == 0) e_be = 4'(1 << ln);
                else if (sz == 1) e_be = (ln < 2) ? 4'b0011 : 4'b1100;
                else e_be = 4'b1111;
                drive(b, o, 2'(sz), 1'(un), 1'(st), rd, sd);
                check("R1 sweep addr", eff_addr, 32'h1000_0100 + ln);
                check("R2 sweep err", {31'h0, addr_err}, {31'h0, e_err});
                if (e_err) begin
                  check("R3 err be", {28'h0, wr_be}, 32'h0);
                  check("R10 err load", load_data, 32'h0);
                end else begin
                  check("R4 be", {28'h0, wr_be}, {28'h0, e_be});
                  if (sz == 0) check("R6 byte lane", load_data, e_ld);
                  else if (sz == 1) check("R7 half lane", load_data, e_ld);
                  else check("R9 word pass", load_data, e_ld);
                  if (sz != 2) check("R8 extend", load_data, e_ld);
                end
                if (sz != 3) check("R5 store data", wr_data, e_wd);
              end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule